// File: doc/BRIEF.md
# Two-Level Software Reset Controller

This block lets software reset a device and its ports through a small byte-wide register file. One device control register and one mode register per port each hold two reset bits next to six configuration bits. The top bit of a register is a master reset: while it is set, every other bit under its scope returns to its default value. The top bit itself keeps whatever software wrote, so the reset stays in force until software writes it back to zero. The bit below it is a logic reset: it holds the datapath in reset but leaves all configuration bits as they are.

A device-level reset of either kind reaches the core reset output and every port reset output. A port-level reset reaches only that port. A device master reset also clears every port register. After a device master reset is released, a guard counter keeps the access-ready flag low for a parameterised number of cycles. Host logic uses this flag to hold back accesses to tables that are not yet safe to touch. The same guard runs after power-on reset.

Top module: `soft_reset_ctrl`

## Requirements
- R1: After power-on reset is released, every register reads 0x00, `core_rst_n` and every `port_rst_n` bit are high, and `access_ready` is low.
- R2: Address 0 is the device register and addresses 1 to NUM_PORTS are the port registers for ports 0 to NUM_PORTS-1. A write with `wr_en` stores `wr_data`. When `rd_en` is high, `rd_data` shows the addressed register from the next clock edge. Any other address reads 0x00, and a write to it changes nothing.
- R3: While device bit 7 is set, bits 6:0 of the device register read 0 whatever is written, and bit 7 holds the written value. Every port register reads 0x00, and port writes are ignored.
- R4: While device bit 7 is set, `core_rst_n` and all `port_rst_n` bits are low, from one clock edge after the bit is stored.
- R5: While device bit 6 is set, `core_rst_n` and all `port_rst_n` bits are low. Device and port configuration bits 5:0 keep their values and remain writable.
- R6: While bit 7 of a port register is set, that port's bits 6:0 read 0 whatever is written, and its `port_rst_n` bit is low. Other ports and `core_rst_n` are unaffected.
- R7: While bit 6 of a port register is set, that port's `port_rst_n` bit is low, and its bits 5:0 keep their value.
- R8: `access_ready` is low while device bit 7 is set. If the write that clears bit 7 is taken at clock edge E, `access_ready` stays low through edge E+GUARD_CYCLES-1 and goes high at edge E+GUARD_CYCLES.
- R9: `dev_cfg` shows device bits 5:0, and `port_cfg[6*i+5:6*i]` shows bits 5:0 of port i.
- R10: When every reset bit is clear, `core_rst_n` and `port_rst_n` return high within two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| core_rst_n | output | 1 | Active-low reset to the device core |
| port_rst_n | output | NUM_PORTS | Active-low reset per port |
| dev_cfg | output | 6 | Device configuration bits |
| port_cfg | output | 6*NUM_PORTS | Port configuration bits, port 0 in the low bits |
| access_ready | output | 1 | High once the post-master-reset guard has expired |

## Verification
The reset bits are driven with four separate patterns, and each one tells apart a different part of the scoping. A device master write that carries non-zero configuration bits shows that the master bit is kept while everything else is cleared. A device logic write with the same configuration bits shows that values are kept rather than cleared. A port master write shows that the clear stays within one port and does not spread to its neighbours. A port logic write shows that only that port's reset output moves. The guard flag is sampled one cycle before and at the exact edge where it must rise, so an off-by-one in the counter is caught.

// File: rtl/soft_reset_pkg.sv
package soft_reset_pkg;
  localparam int WORD_W = 8;
  localparam int CFG_W  = 6;

  typedef struct packed {
    logic             mst;
    logic             lgc;
    logic [CFG_W-1:0] cfg;
  } ctl_word_t;
endpackage

// File: rtl/soft_reset_sync.sv
module soft_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/soft_reset_ctlreg.sv
module soft_reset_ctlreg
  import soft_reset_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  ctl_word_t wr_word,
  input  logic      force_clr,
  output ctl_word_t q
);
  ctl_word_t nxt;
  logic      en;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = wr_word;
    if (nxt.mst) begin
      nxt.lgc = 1'b0;
      nxt.cfg = '0;
    end
    if (force_clr) nxt = '0;
  end

  assign en = wr_en | force_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/soft_reset_guard.sv
module soft_reset_guard #(
  parameter int GUARD_CYCLES = 1650
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ready
);
  localparam int CNT_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(GUARD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_nxt = cnt_q;
    if (hold)             cnt_nxt = LOAD;
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  assign cnt_en = hold | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign ready = (cnt_q == '0) & ~hold;
endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
  import soft_reset_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int ADDR_W       = 4,
  parameter int GUARD_CYCLES = 1650
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  output logic                   core_rst_n,
  output logic [NUM_PORTS-1:0]   port_rst_n,
  output logic [5:0]             dev_cfg,
  output logic [6*NUM_PORTS-1:0] port_cfg,
  output logic                   access_ready
);
  logic                       rst_n_s;
  ctl_word_t                  dev_q;
  ctl_word_t                  port_q [NUM_PORTS];
  logic [7:0]                 dev_word;
  logic [8*NUM_PORTS-1:0]     port_words;
  logic                       dev_hit;
  logic [NUM_PORTS-1:0]       port_hit;
  logic                       dev_any;
  logic [7:0]                 rd_nxt;
  logic                       core_nxt;
  logic [NUM_PORTS-1:0]       port_nxt;

  soft_reset_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign dev_hit = wr_en & (addr == '0);

  soft_reset_ctlreg u_dev (
    .clk(clk), .rst_n(rst_n_s), .wr_en(dev_hit),
    .wr_word(ctl_word_t'(wr_data)), .force_clr(1'b0), .q(dev_q)
  );

  assign dev_word = dev_q;
  assign dev_cfg  = dev_q.cfg;
  assign dev_any  = dev_q.mst | dev_q.lgc;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign port_hit[i] = wr_en & (addr == ADDR_W'(i + 1));

    soft_reset_ctlreg u_port (
      .clk(clk), .rst_n(rst_n_s), .wr_en(port_hit[i]),
      .wr_word(ctl_word_t'(wr_data)), .force_clr(dev_q.mst), .q(port_q[i])
    );

    assign port_words[8*i +: 8] = port_q[i];
    assign port_cfg[6*i +: 6]   = port_q[i].cfg;
    assign port_nxt[i] = ~(dev_any | port_q[i].mst | port_q[i].lgc);
  end

  assign core_nxt = ~dev_any;

  soft_reset_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n_s), .hold(dev_q.mst), .ready(access_ready)
  );

  always_comb begin
    rd_nxt = '0;
    if (addr == '0) rd_nxt = dev_word;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr == ADDR_W'(i + 1)) rd_nxt = port_words[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      core_rst_n <= 1'b0;
      port_rst_n <= '0;
    end else begin
      core_rst_n <= core_nxt;
      port_rst_n <= port_nxt;
    end
  end
endmodule

// File: rtl/soft_reset_ctrl_chk.sv
module soft_reset_ctrl_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [7:0]             dev_word,
  input logic [8*NUM_PORTS-1:0] port_words,
  input logic                   core_rst_n,
  input logic [NUM_PORTS-1:0]   port_rst_n,
  input logic                   access_ready
);
  a_r3_dev_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[7] |-> dev_word[6:0] == 7'd0);

  a_r3_ports_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[7] && $past(dev_word[7]) |-> port_words == '0);

  a_r4_master_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[7] |=> !core_rst_n && port_rst_n == '0);

  a_r5_logic_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[6] |=> !core_rst_n && port_rst_n == '0);

  a_r5_logic_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[6] && !wr_en |=> $stable(dev_word[5:0]));

  a_r8_ready_low_in_master: assert property (@(posedge clk) disable iff (!rst_n)
    dev_word[7] |-> !access_ready);

  a_r8_ready_low_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_word[7]) |-> !access_ready);

  a_r10_core_release: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_word[7] && !dev_word[6] |=> core_rst_n);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    a_r6_port_master_out: assert property (@(posedge clk) disable iff (!rst_n)
      port_words[8*i+7] |=> !port_rst_n[i]);

    a_r6_port_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      port_words[8*i+7] |-> port_words[8*i +: 7] == 7'd0);

    a_r7_port_logic_out: assert property (@(posedge clk) disable iff (!rst_n)
      port_words[8*i+6] |=> !port_rst_n[i]);
  end
endmodule

bind soft_reset_ctrl soft_reset_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .dev_word(dev_word),
  .port_words(port_words), .core_rst_n(core_rst_n), .port_rst_n(port_rst_n),
  .access_ready(access_ready)
);

// File: tb/soft_reset_ctrl_test.sv
module soft_reset_ctrl_test;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int GUARD = 1650;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic core_rst_n;
  logic [NP-1:0] port_rst_n;
  logic [5:0] dev_cfg;
  logic [6*NP-1:0] port_cfg;
  logic access_ready;
  int checks = 0, failures = 0;

  soft_reset_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW), .GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .core_rst_n(core_rst_n),
    .port_rst_n(port_rst_n), .dev_cfg(dev_cfg), .port_cfg(port_cfg),
    .access_ready(access_ready)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(posedge clk); @(negedge clk); rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    // R1
    check("R1 ready", access_ready, 0);
    settle();
    for (int a = 0; a <= NP; a++) rd_chk("R1 regs", a, 8'h00);
    check("R1 core", core_rst_n, 1);
    check("R1 ports", port_rst_n, 4'hF);
    repeat (GUARD + 5) @(posedge clk);
    @(negedge clk);
    check("R1 ready after guard", access_ready, 1);
  endtask

  task automatic t_regs();
    // R2 R9
    wr(0, 8'h15); wr(1, 8'h2A); wr(2, 8'h11); wr(4, 8'h3C);
    rd_chk("R2 dev", 0, 8'h15);
    rd_chk("R2 p0", 1, 8'h2A);
    rd_chk("R2 p3", 4, 8'h3C);
    check("R9 dev_cfg", dev_cfg, 6'h15);
    check("R9 port_cfg", port_cfg, {6'h3C, 6'h00, 6'h11, 6'h2A});
    wr(9, 8'hFF);
    rd_chk("R2 unmapped", 9, 8'h00);
    rd_chk("R2 unmapped no side effect", 0, 8'h15);
    check("R2 unmapped outputs", {core_rst_n, port_rst_n}, 5'h1F);
  endtask

  task automatic t_dev_master();
    wr(0, 8'h95);
    settle();
    rd_chk("R3 dev keeps mst only", 0, 8'h80);
    rd_chk("R3 p0 cleared", 1, 8'h00);
    rd_chk("R3 p3 cleared", 4, 8'h00);
    check("R3 cfg outputs", {dev_cfg, port_cfg}, 30'h0);
    check("R4 core", core_rst_n, 0);
    check("R4 ports", port_rst_n, 4'h0);
    wr(0, 8'hBF);
    rd_chk("R3 write masked", 0, 8'h80);
    wr(2, 8'h3F);
    rd_chk("R3 port write ignored", 2, 8'h00);
    check("R8 low in master", access_ready, 0);
    wr(0, 8'h00);
    repeat (GUARD - 1) @(posedge clk);
    @(negedge clk);
    check("R8 low at E+G-1", access_ready, 0);
    check("R10 core released", core_rst_n, 1);
    check("R10 ports released", port_rst_n, 4'hF);
    @(posedge clk); @(negedge clk);
    check("R8 high at E+G", access_ready, 1);
  endtask

  task automatic t_dev_logic();
    wr(0, 8'h15); wr(1, 8'h2A);
    wr(0, 8'h55);
    settle();
    check("R5 core", core_rst_n, 0);
    check("R5 ports", port_rst_n, 4'h0);
    rd_chk("R5 dev kept", 0, 8'h55);
    rd_chk("R5 p0 kept", 1, 8'h2A);
    wr(1, 8'h23);
    rd_chk("R5 p0 writable", 1, 8'h23);
    check("R5 ready unaffected", access_ready, 1);
    wr(0, 8'h15);
    settle();
    check("R10 core after logic", core_rst_n, 1);
  endtask

  task automatic t_port_master();
    wr(2, 8'h2A); wr(2, 8'hAA);
    settle();
    rd_chk("R6 p1 mst only", 2, 8'h80);
    check("R6 port out", port_rst_n, 4'b1101);
    check("R6 core", core_rst_n, 1);
    rd_chk("R6 p0 untouched", 1, 8'h23);
    wr(2, 8'hC5);
    rd_chk("R6 write masked", 2, 8'h80);
    wr(2, 8'h00);
    settle();
    check("R10 port released", port_rst_n, 4'hF);
  endtask

  task automatic t_port_logic();
    wr(3, 8'h53);
    settle();
    rd_chk("R7 p2 kept", 3, 8'h53);
    check("R7 port out", port_rst_n, 4'b1011);
    check("R7 cfg", port_cfg[17:12], 6'h13);
    check("R7 core", core_rst_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regs();
    t_dev_master();
    t_dev_logic();
    t_port_master();
    t_port_logic();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule